// File: doc/BRIEF.md
# Shared-Bus Host Register Interface

This block lets an external processor reach a bank of byte-wide registers over eight shared address/data lines. Each bus cycle begins with an address phase. A latch strobe marks the address, and the block captures it when that strobe falls. A data phase follows, in which the processor either writes a byte into the addressed register or reads one back. All host pins are brought into the internal clock domain through two-flop synchronizers. Strobe edges are found by comparing each synchronized sample with the one before it, so every strobe must be held for at least three clock cycles.

Two strobe conventions are supported, and a mode pin chooses between them. It is sampled once after reset.

- Mode pin low (Intel-style): the separate read and write strobes are both active low.
- Mode pin high (Motorola-style): one data strobe is active high, and a direction line selects the transfer (high reads, low writes).

The two conventions also end a read differently. In Intel-style mode the read ends when the read strobe rises. In Motorola-style mode it ends when the data strobe falls. The read-data driver is enabled only while the active-low chip select is asserted and a read strobe is in effect. At all other times the lines are left to the pad as high impedance.

The register bank has 256 locations. The top sixteen locations hold fixed identification bytes and do not accept writes.

Top module: `hb_bridge`

## Requirements
- R1: After reset `ad_oe` is low, and every register at 0x00–0xEF reads 0x00.
- R2: `mode_sel` is sampled on the first clock after reset is released (0 selects Intel-style, 1 selects Motorola-style). Any later change has no effect until the next reset.
- R3: The address is captured from `ad_in` when `ale_as` falls, in both modes. A rise of `ale_as` captures nothing.
- R4: Intel-style write: `wr_rw` low with `cs_n` low is a write pulse. The byte last seen on `ad_in` during the pulse is stored at the latched address when `wr_rw` rises.
- R5: Motorola-style write: `rd_ds` high with `wr_rw` low and `cs_n` low is a write pulse. The byte is stored when `rd_ds` falls.
- R6: Read: while `cs_n` is low and the read strobe is active, `ad_oe` is high and `ad_out` carries the addressed byte. The read strobe is `rd_ds` low in Intel-style mode, or `rd_ds` high with `wr_rw` high in Motorola-style mode. A write and a drive never overlap.
- R7: `ad_oe` returns low at most four clocks after the read ends. In Intel-style mode the read ends when `rd_ds` rises; in Motorola-style mode it ends when `rd_ds` falls.
- R8: With `cs_n` high, strobes neither write a register nor raise `ad_oe`.
- R9: Writes to 0xF0–0xFF are ignored. Those locations read 0x50 plus the low four address bits.
- R10: When a write pulse ends in the same synchronized sample as a new address is captured, the byte goes to the previously latched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Strobe convention: 0 Intel-style, 1 Motorola-style |
| cs_n | input | 1 | Active-low chip select |
| ale_as | input | 1 | Address latch strobe; the address is taken on its falling edge |
| rd_ds | input | 1 | Intel-style: read strobe, active low. Motorola-style: data strobe, active high |
| wr_rw | input | 1 | Intel-style: write strobe, active low. Motorola-style: direction, 1 read and 0 write |
| ad_in | input | 8 | Value received from the shared address/data lines |
| ad_out | output | 8 | Read byte to drive onto the shared lines |
| ad_oe | output | 1 | Pad drive enable for `ad_out`; low means high impedance |

## Verification
The end of a write pulse and the capture of the next address can land in the same synchronized sample. The bench provokes this in Intel-style mode by raising the write strobe, dropping the latch strobe and placing a new address on the lines, all in the same cycle. The latch strobe has already been raised during the data phase. The case is judged by reading both addresses back: the written byte must be at the old address, and the new address must be untouched.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        MODE_INTEL = 1'b0,
        MODE_MOTO  = 1'b1
    } bus_mode_e;

    // cycles after reset before edge detection is trusted (sync pipe fill)
    localparam int WARM_CYCLES = 3;
    localparam int WARM_W      = $clog2(WARM_CYCLES + 1);

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/hb_proto.sv
module hb_proto
    import hb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_pin,
    input  logic          cs_n_s,
    input  logic          ale_s,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic [DW-1:0] ad_s,
    output bus_mode_e     mode_o,
    output logic          ready_o,
    output logic [DW-1:0] lat_addr_o,
    output logic          wr_en_o,
    output logic [DW-1:0] wr_data_o,
    output logic          rd_live_o,
    output logic          rd_act_o
);

    localparam logic [WARM_W-1:0] WARM_MAX = WARM_W'(WARM_CYCLES);

    typedef struct packed {
        bus_mode_e         mode;
        logic [WARM_W-1:0] warm;
        logic              ale_p;
        logic              wr_p;
        logic              rd;
        logic [DW-1:0]     addr;
        logic [DW-1:0]     wdata;
    } proto_st_t;

    proto_st_t st_d, st_q;
    logic      ready;
    logic      wr_now;
    logic      rd_now;
    logic      commit;

    always_comb begin
        st_d  = st_q;
        ready = (st_q.warm == WARM_MAX);
        if (!ready) st_d.warm = st_q.warm + 1'b1;
        if (st_q.warm == '0) st_d.mode = bus_mode_e'(mode_pin);

        if (st_q.mode == MODE_INTEL) begin
            wr_now = !wr_s && !cs_n_s;
            rd_now = !rd_s && !cs_n_s;
        end else begin
            wr_now = rd_s && !wr_s && !cs_n_s;
            rd_now = rd_s &&  wr_s && !cs_n_s;
        end
        wr_now = wr_now && ready;
        rd_now = rd_now && ready;

        if (ready && st_q.ale_p && !ale_s) st_d.addr = ad_s;
        if (wr_now) st_d.wdata = ad_s;

        commit     = st_q.wr_p && !wr_now;
        st_d.ale_p = ale_s;
        st_d.wr_p  = wr_now;
        st_d.rd    = rd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o     = st_q.mode;
    assign ready_o    = ready;
    assign lat_addr_o = st_q.addr;
    assign wr_en_o    = commit;
    assign wr_data_o  = st_q.wdata;
    assign rd_live_o  = rd_now;
    assign rd_act_o   = st_q.rd;

endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int          DW      = 8,
    parameter int          DEPTH   = 256,
    parameter int          RO_BASE = 240,
    parameter logic [7:0]  ID_TAG  = 8'h50
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);

    localparam int AW       = $clog2(DEPTH);
    localparam int RO_LOW_W = $clog2(DEPTH - RO_BASE);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic          in_ro;

    assign in_ro = (addr >= AW'(RO_BASE));

    always_comb begin
        mem_d = mem_q;
        if (we && !in_ro) mem_d[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = in_ro ? (DW'(ID_TAG) | DW'(addr[RO_LOW_W-1:0])) : mem_q[addr];

endmodule

// File: rtl/hb_bridge.sv
module hb_bridge
    import hb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          cs_n,
    input  logic          ale_as,
    input  logic          rd_ds,
    input  logic          wr_rw,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe
);

    localparam int SW    = DW + 4;
    localparam int DEPTH = 1 << DW;

    logic [SW-1:0] pins_s;
    logic          cs_n_s, ale_s, rd_s, wr_s;
    logic [DW-1:0] ad_s;
    bus_mode_e     mode_q;
    logic          ready;
    logic [DW-1:0] lat_addr;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          rd_live;

    hb_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, ale_as, rd_ds, wr_rw, ad_in}),
        .q     (pins_s)
    );

    assign {cs_n_s, ale_s, rd_s, wr_s, ad_s} = pins_s;

    hb_proto #(.DW(DW)) u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pin   (mode_sel),
        .cs_n_s     (cs_n_s),
        .ale_s      (ale_s),
        .rd_s       (rd_s),
        .wr_s       (wr_s),
        .ad_s       (ad_s),
        .mode_o     (mode_q),
        .ready_o    (ready),
        .lat_addr_o (lat_addr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .rd_live_o  (rd_live),
        .rd_act_o   (ad_oe)
    );

    hb_regfile #(.DW(DW), .DEPTH(DEPTH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .addr  (lat_addr),
        .wdata (wr_data),
        .rdata (ad_out)
    );

endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ad_oe,
    input logic [DW-1:0] ad_out,
    input logic          rd_live,
    input logic          wr_en,
    input logic [DW-1:0] lat_addr,
    input logic          mode_q,
    input logic          ready,
    input logic          cs_n_s
);

    // R8: the driver is enabled only after a cycle with the select asserted
    p_oe_needs_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(!cs_n_s));

    // R7: once the read condition drops, the driver is off on the next edge
    p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_live) |=> !ad_oe);

    // R6: a commit never coincides with an active drive
    p_dir_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && ad_oe));

    // R2: once the pipeline is warm the captured mode stays put
    p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(mode_q));

    // R9: fixed identification bytes in the top sixteen locations
    p_ro_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_addr[DW-1:DW-4] == 4'hF) |-> (ad_out == {4'h5, lat_addr[3:0]}));

endmodule

bind hb_bridge hb_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ad_oe    (ad_oe),
    .ad_out   (ad_out),
    .rd_live  (rd_live),
    .wr_en    (wr_en),
    .lat_addr (lat_addr),
    .mode_q   (mode_q),
    .ready    (ready),
    .cs_n_s   (cs_n_s)
);

// File: tb/hb_bridge_bench.sv
module hb_bridge_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       cs_n = 1'b1;
    logic       ale_as = 1'b0;
    logic       rd_ds = 1'b1;
    logic       wr_rw = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;

    typedef struct {
        logic       oe;
        logic [7:0] data;
        bit         chk_data;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    hb_bridge u_hb_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .cs_n     (cs_n),
        .ale_as   (ale_as),
        .rd_ds    (rd_ds),
        .wr_rw    (wr_rw),
        .ad_in    (ad_in),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe)
    );

    // monitor: compare outputs against queued expectations between edges
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (ad_oe !== it.oe) begin
                n_fail++;
                $display("FAIL %s: ad_oe=%0b expected %0b", it.tag, ad_oe, it.oe);
            end else if (it.chk_data && ad_out !== it.data) begin
                n_fail++;
                $display("FAIL %s: ad_out=%02h expected %02h", it.tag, ad_out, it.data);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic oe, input logic [7:0] d, input string tag);
        exp_item_t it;
        it.oe = oe; it.data = d; it.chk_data = oe; it.tag = tag;
        exp_q.push_back(it);
        cyc(1);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        ad_in = a; ale_as = 1'b1; cyc(4);
        ale_as = 1'b0; cyc(4);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0; mode_sel = m; cs_n = 1'b1; ale_as = 1'b0;
        rd_ds = m ? 1'b0 : 1'b1; wr_rw = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(6);
    endtask

    task automatic i_write(input logic [7:0] a, input logic [7:0] d, input logic sel_n);
        cs_n = sel_n; addr_phase(a);
        ad_in = d; wr_rw = 1'b0; cyc(6);
        wr_rw = 1'b1; cyc(4);
        cs_n = 1'b1; cyc(1);
    endtask

    task automatic i_read(input logic [7:0] a, input logic [7:0] e, input logic sel_n, input string tag);
        cs_n = sel_n; addr_phase(a);
        ad_in = 8'h00; rd_ds = 1'b0; cyc(5);
        expect_out(!sel_n, e, tag);
        rd_ds = 1'b1; cyc(4);
        expect_out(1'b0, 8'h00, {tag, " release R7"});
        cs_n = 1'b1; cyc(1);
    endtask

    task automatic m_write(input logic [7:0] a, input logic [7:0] d);
        cs_n = 1'b0; addr_phase(a);
        ad_in = d; wr_rw = 1'b0; cyc(2);
        rd_ds = 1'b1; cyc(6);
        rd_ds = 1'b0; cyc(4);
        wr_rw = 1'b1; cs_n = 1'b1; cyc(1);
    endtask

    task automatic m_read(input logic [7:0] a, input logic [7:0] e, input string tag);
        cs_n = 1'b0; addr_phase(a);
        ad_in = 8'h00; wr_rw = 1'b1; rd_ds = 1'b1; cyc(5);
        expect_out(1'b1, e, tag);
        rd_ds = 1'b0; cyc(4);
        expect_out(1'b0, 8'h00, {tag, " release R7"});
        cs_n = 1'b1; cyc(1);
    endtask

    initial begin
        do_reset(1'b0);
        expect_out(1'b0, 8'h00, "R1 oe low after reset");
        i_read(8'h10, 8'h00, 1'b0, "R1 reset contents");

        i_write(8'h10, 8'hA5, 1'b0);
        i_read(8'h10, 8'hA5, 1'b0, "R4 R3 R6 intel write/read");
        i_write(8'h22, 8'h3C, 1'b0);
        i_read(8'h22, 8'h3C, 1'b0, "R4 second address");
        i_read(8'h10, 8'hA5, 1'b0, "R3 first address kept");

        i_write(8'h10, 8'hFF, 1'b1);
        i_read(8'h10, 8'hA5, 1'b0, "R8 deselected write ignored");
        i_read(8'h10, 8'h00, 1'b1, "R8 deselected read no drive");

        i_write(8'hF3, 8'h00, 1'b0);
        i_read(8'hF3, 8'h53, 1'b0, "R9 read-only ID");
        i_read(8'hFE, 8'h5E, 1'b0, "R9 read-only ID high");

        // R10: write end and address capture in the same cycle
        cs_n = 1'b0; addr_phase(8'h30);
        ad_in = 8'h99; wr_rw = 1'b0; cyc(3);
        ale_as = 1'b1; cyc(3);
        wr_rw = 1'b1; ale_as = 1'b0; ad_in = 8'h31; cyc(5);
        cs_n = 1'b1; cyc(1);
        i_read(8'h30, 8'h99, 1'b0, "R10 data at old address");
        i_read(8'h31, 8'h00, 1'b0, "R10 new address untouched");

        // R2: mode pin change after start is ignored
        mode_sel = 1'b1; cyc(2);
        i_read(8'h22, 8'h3C, 1'b0, "R2 mode change ignored");

        do_reset(1'b1);
        m_read(8'h10, 8'h00, "R1 cleared after second reset");
        m_write(8'h44, 8'h7E);
        m_read(8'h44, 8'h7E, "R5 R6 moto write/read");
        m_write(8'hFA, 8'h11);
        m_read(8'hFA, 8'h5A, "R9 moto read-only");

        cyc(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule